// File: doc/BRIEF.md
# UART Host Register Interface

This block sits between a host processor and the serial engines of a simple UART. The host reaches four byte-wide registers through a 2-bit address, a write strobe and a chip select, all over one shared bidirectional 8-bit data bus. The registers are the transmit holding byte, the receive holding byte, a status byte and a control byte. The block drives the bus only while it is returning a read value and leaves it in high impedance at every other time. It also raises one interrupt line, gated by two enables held in the control byte.

On the serial side, the transmit holding byte leaves the block as a valid/ready stream. `tx_valid` is high while the holding byte is full. The transmit shifter takes the byte by raising `tx_ready` in a cycle where `tx_valid` is high. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds still. The receive side has no back-pressure, because a serial line cannot be stalled. Each `rx_valid` pulse hands over one byte and its framing-error flag. If the previous byte has not been read yet, the new byte is counted as an overrun. The control byte also carries a 3-bit rate select for the external baud divider, and that select resets to the fastest rate.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, the status byte reads 0x80, the control byte reads 0x00, `baud_sel` is 0, `irq` is 0 and `tx_valid` is 0.
- R2: When `cs`=1 and `wr`=0, the block drives the bus combinationally from the address. Address 00 gives the receive byte, address 01 gives the status byte and addresses 10 or 11 give the control byte. In the status byte, bit 7 is transmit-empty, bit 6 is receive-full, bit 1 is overrun and bit 0 is framing error; all other bits read 0.
- R3: A write (`cs`=1, `wr`=1) to address 10 or 11 stores the control byte at the clock edge. Bit 7 is the transmit interrupt enable, bit 6 is the receive interrupt enable and bits 2:0 are the rate select. The rate select goes out on `baud_sel`; value k selects 38400>>k baud. Bits 5:3 read back as 0.
- R4: The bus is in high impedance whenever `cs`=0 or `wr`=1. A write to address 01 changes no register.
- R5: With `cs`=0, no write strobe has any effect on any register.
- R6: A write to address 00 while transmit-empty is 1 loads the transmit byte and clears transmit-empty. `tx_valid` and `tx_data` show the byte from the next cycle. A write to address 00 while transmit-empty is 0 is ignored.
- R7: `tx_valid` equals NOT transmit-empty. A cycle with `tx_valid` and `tx_ready` both high sets transmit-empty at that edge. While `tx_valid` is high and `tx_ready` is low, `tx_data` is stable.
- R8: An `rx_valid` pulse while receive-full is 0 loads the receive byte from `rx_data`, loads the framing-error bit from `rx_frame_err` and sets receive-full.
- R9: A read of address 00 clears receive-full and overrun at that clock edge. If `rx_valid` arrives in the same cycle, the new byte loads and receive-full stays 1 with no overrun.
- R10: An `rx_valid` pulse while receive-full is 1 and no read of address 00 is taking place sets overrun. The receive byte and the framing-error bit keep their old values.
- R11: `irq` = (transmit enable AND transmit-empty) OR (receive enable AND (receive-full OR overrun)). It is combinational from the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, qualifies every access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| dbus | inout | 8 | Shared data bus, tri-stated when not read |
| irq | output | 1 | Combined interrupt request |
| baud_sel | output | BAUD_W | Rate select to the baud divider |
| tx_data | output | 8 | Transmit byte stream data |
| tx_valid | output | 1 | Transmit byte held |
| tx_ready | input | 1 | Transmit shifter takes the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle pulse, received byte present |
| rx_frame_err | input | 1 | Framing error of the byte on `rx_data` |

## Verification
Every flag in this block shows up on the status byte and on `irq` in the cycle after the edge that changes it. A wrong transmit-empty, receive-full or overrun flag therefore appears in the very next status read, and also on `irq` once the matching enable is set. A control field that is stored wrongly shows in the next readback and on `baud_sel` right away. A wrong decode shows either as a bus value where high impedance is expected or as a register that changes after an access to another address, and both are visible one cycle after the access.

// File: rtl/uhi_pkg.sv
package uhi_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned CTRL_TIE  = 7;
  localparam int unsigned CTRL_RIE  = 6;
  localparam int unsigned STAT_TDRE = 7;
  localparam int unsigned STAT_RDRF = 6;
  localparam int unsigned STAT_OE   = 1;
  localparam int unsigned STAT_FE   = 0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RDR  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic tdre;
    logic rdrf;
    logic oe;
    logic fe;
  } flags_t;
endpackage

// File: rtl/uhi_decode.sv
module uhi_decode
  import uhi_pkg::*;
(
  input  logic       cs,
  input  logic       wr,
  input  logic [1:0] addr,
  output logic       wr_tdr,
  output logic       wr_ctrl,
  output logic       rd_rdr,
  output rd_sel_e    rd_sel
);
  always_comb begin
    wr_tdr  = 1'b0;
    wr_ctrl = 1'b0;
    rd_rdr  = 1'b0;
    rd_sel  = SEL_NONE;
    if (cs) begin
      if (addr[1]) begin
        if (wr) wr_ctrl = 1'b1;
        else    rd_sel  = SEL_CTRL;
      end else if (addr[0]) begin
        if (!wr) rd_sel = SEL_STAT;
      end else begin
        if (wr) begin
          wr_tdr = 1'b1;
        end else begin
          rd_sel = SEL_RDR;
          rd_rdr = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uhi_ctrl_reg.sv
module uhi_ctrl_reg
  import uhi_pkg::*;
#(
  parameter int unsigned BAUD_W   = 3,
  parameter int unsigned BAUD_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wd_tie,
  input  logic              wd_rie,
  input  logic [BAUD_W-1:0] wd_baud,
  output logic              tie,
  output logic              rie,
  output logic [BAUD_W-1:0] baud_sel,
  output logic [DW-1:0]     ctrl_rd
);
  localparam logic [BAUD_W-1:0] BAUD_INIT = BAUD_W'(BAUD_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tie      <= 1'b0;
      rie      <= 1'b0;
      baud_sel <= BAUD_INIT;
    end else if (wr_ctrl) begin
      tie      <= wd_tie;
      rie      <= wd_rie;
      baud_sel <= wd_baud;
    end
  end

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[CTRL_TIE]    = tie;
    ctrl_rd[CTRL_RIE]    = rie;
    ctrl_rd[BAUD_W-1:0]  = baud_sel;
  end

  // R5 / R3: control state moves only on a decoded control write
  assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable({tie, rie, baud_sel}));
endmodule

// File: rtl/uhi_tx_hold.sv
module uhi_tx_hold
  import uhi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_tdr,
  input  logic [DW-1:0] wdata,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tdre
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdre    <= 1'b1;
      tx_data <= '0;
    end else if (tx_valid && tx_ready) begin
      tdre <= 1'b1;
    end else if (wr_tdr && tdre) begin
      tx_data <= wdata;
      tdre    <= 1'b0;
    end
  end

  assign tx_valid = !tdre;

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_tx_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid);

  assert_tx_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tdr && !tx_valid |=> tx_valid && tx_data == $past(wdata));
endmodule

// File: rtl/uhi_rx_hold.sv
module uhi_rx_hold
  import uhi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_frame_err,
  input  logic          rd_rdr,
  output logic [DW-1:0] rdr,
  output logic          rdrf,
  output logic          oe,
  output logic          fe
);
  logic accept;
  assign accept = rx_valid && (!rdrf || rd_rdr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr  <= '0;
      rdrf <= 1'b0;
      oe   <= 1'b0;
      fe   <= 1'b0;
    end else if (accept) begin
      rdr  <= rx_data;
      fe   <= rx_frame_err;
      rdrf <= 1'b1;
      oe   <= 1'b0;
    end else if (rx_valid) begin
      oe <= 1'b1;
    end else if (rd_rdr) begin
      rdrf <= 1'b0;
      oe   <= 1'b0;
    end
  end

  assert_rx_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rdrf);

  assert_overrun_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rdrf && !rd_rdr |=> oe && $stable(rdr) && $stable(fe));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rdr && !rx_valid |=> !rdrf && !oe);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uhi_pkg::*;
#(
  parameter int unsigned BAUD_W   = 3,
  parameter int unsigned BAUD_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic [1:0]        addr,
  inout  wire  [7:0]        dbus,
  output logic              irq,
  output logic [BAUD_W-1:0] baud_sel,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_frame_err
);
  logic          wr_tdr, wr_ctrl, rd_rdr;
  rd_sel_e       rd_sel;
  logic          tie, rie;
  logic [DW-1:0] ctrl_rd, rdr, stat_rd, rd_val, bus_in;
  flags_t        flg;

  assign bus_in = dbus;

  uhi_decode i_decode (
    .cs      (cs),
    .wr      (wr),
    .addr    (addr),
    .wr_tdr  (wr_tdr),
    .wr_ctrl (wr_ctrl),
    .rd_rdr  (rd_rdr),
    .rd_sel  (rd_sel)
  );

  uhi_ctrl_reg #(.BAUD_W(BAUD_W), .BAUD_RST(BAUD_RST)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wd_tie   (bus_in[CTRL_TIE]),
    .wd_rie   (bus_in[CTRL_RIE]),
    .wd_baud  (bus_in[BAUD_W-1:0]),
    .tie      (tie),
    .rie      (rie),
    .baud_sel (baud_sel),
    .ctrl_rd  (ctrl_rd)
  );

  uhi_tx_hold i_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_tdr   (wr_tdr),
    .wdata    (bus_in),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tdre     (flg.tdre)
  );

  uhi_rx_hold i_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_frame_err (rx_frame_err),
    .rd_rdr       (rd_rdr),
    .rdr          (rdr),
    .rdrf         (flg.rdrf),
    .oe           (flg.oe),
    .fe           (flg.fe)
  );

  always_comb begin
    stat_rd            = '0;
    stat_rd[STAT_TDRE] = flg.tdre;
    stat_rd[STAT_RDRF] = flg.rdrf;
    stat_rd[STAT_OE]   = flg.oe;
    stat_rd[STAT_FE]   = flg.fe;
  end

  always_comb begin
    case (rd_sel)
      SEL_RDR:  rd_val = rdr;
      SEL_STAT: rd_val = stat_rd;
      SEL_CTRL: rd_val = ctrl_rd;
      default:  rd_val = '0;
    endcase
  end

  assign dbus = (rd_sel != SEL_NONE) ? rd_val : 8'hzz;

  assign irq = (tie && flg.tdre) || (rie && (flg.rdrf || flg.oe));

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tie && !rie |-> !irq);

  assert_irq_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tie && !tx_valid |-> irq);
endmodule

// File: tb/test_uart_host_regs.sv
`timescale 1ns/1ps
module test_uart_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'b00;
  logic       tb_en = 1'b0;
  logic [7:0] tb_val = 8'h00;
  logic       tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0, rx_frame_err = 1'b0;
  wire  [7:0] dbus;
  logic       irq, tx_valid;
  logic [2:0] baud_sel;
  logic [7:0] tx_data;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  assign dbus = tb_en ? tb_val : 8'hzz;
  for (genvar b = 0; b < 8; b++) begin : g_pu
    pullup (dbus[b]);
  end

  uart_host_regs i_uart_host_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .dbus(dbus),
    .irq(irq), .baud_sel(baud_sel), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); cs = 1; wr = 1; addr = a; tb_val = v; tb_en = 1;
    @(negedge clk); cs = 0; wr = 0; tb_en = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); cs = 1; wr = 0; addr = a;
    #1 v = dbus;
    @(negedge clk); cs = 0;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic f);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_frame_err = f;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic tx_take();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, a0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 irq", irq, 0); chk("R1 tx_valid", tx_valid, 0); chk("R1 baud", baud_sel, 0);
    chk("R4 idle bus", dbus, 8'hFF);
    rd_reg(2'b01, r); chk("R1 status", r, 8'h80);
    rd_reg(2'b10, r); chk("R1 ctrl", r, 8'h00);

    // R3 R2 R11 sweep of the control byte over all values, both control addresses
    for (int v = 0; v < 256; v++) begin
      logic [1:0] ca;
      ca = (v[0]) ? 2'b11 : 2'b10;
      wr_reg(ca, v[7:0]);
      chk("R3 baud_sel", baud_sel, v[2:0]);
      chk("R11 irq tx-empty", irq, v[7]);
      rd_reg(ca ^ 2'b01, r);
      chk("R3 readback", r, v[7:0] & 8'hC7);
    end
    wr_reg(2'b10, 8'h00);

    // R5 cs low: no writes take effect; bus stays released
    @(negedge clk); cs = 0; wr = 1; addr = 2'b10; tb_val = 8'hC5; tb_en = 1;
    @(negedge clk); addr = 2'b00;
    @(negedge clk); tb_en = 0; wr = 0; addr = 2'b01;
    #1 chk("R4 cs low read", dbus, 8'hFF);
    chk("R5 tdr untouched", tx_valid, 0);
    rd_reg(2'b10, r); chk("R5 ctrl untouched", r, 8'h00);

    // R4 write to status address is inert and bus not driven
    @(negedge clk); cs = 1; wr = 1; addr = 2'b01; tb_en = 0;
    #1 chk("R4 write cycle bus", dbus, 8'hFF);
    @(negedge clk); cs = 0; wr = 0;
    wr_reg(2'b01, 8'h00);
    rd_reg(2'b01, r); chk("R4 status after 01 write", r, 8'h80);
    rd_reg(2'b10, r); chk("R4 ctrl after 01 write", r, 8'h00);

    // R6 R7 transmit path sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 17 + 3);
      wr_reg(2'b00, v);
      chk("R6 tx_valid", tx_valid, 1); chk("R6 tx_data", tx_data, v);
      rd_reg(2'b01, r); chk("R6 tdre cleared", r, 8'h00);
      wr_reg(2'b00, ~v);
      chk("R6 write while full ignored", tx_data, v);
      @(negedge clk);
      chk("R7 hold valid", tx_valid, 1); chk("R7 hold data", tx_data, v);
      tx_take();
      chk("R7 drained", tx_valid, 0);
      rd_reg(2'b01, r); chk("R7 tdre set", r, 8'h80);
    end

    // R8 R9 receive path sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 29 + 7);
      rx_push(v, v[0]);
      rd_reg(2'b01, r); chk("R8 status full", r, 8'hC0 | {7'b0, v[0]});
      rd_reg(2'b00, r); chk("R8 rdr data", r, v);
      rd_reg(2'b01, r); chk("R9 cleared", r, 8'h80 | {7'b0, v[0]});
    end

    // R10 overrun keeps old byte and FE
    a0 = 8'h3C; b0 = 8'hA5;
    rx_push(a0, 1'b0);
    rx_push(b0, 1'b1);
    rd_reg(2'b01, r); chk("R10 overrun status", r, 8'hC2);
    rd_reg(2'b00, r); chk("R10 old byte kept", r, a0);
    rd_reg(2'b01, r); chk("R9 oe cleared by read", r, 8'h80);

    // R9 read and new byte in the same cycle
    rx_push(a0, 1'b0);
    @(negedge clk); cs = 1; wr = 0; addr = 2'b00; rx_valid = 1; rx_data = b0; rx_frame_err = 1'b0;
    #1 r = dbus; chk("R9 read returns old", r, a0);
    @(negedge clk); cs = 0; rx_valid = 0;
    rd_reg(2'b01, r); chk("R9 simultaneous keeps full", r, 8'hC0);
    rd_reg(2'b00, r); chk("R9 new byte", r, b0);

    // R11 interrupt matrix
    for (int e = 0; e < 4; e++) begin
      logic t, q;
      t = e[1]; q = e[0];
      wr_reg(2'b10, {t, q, 6'b0});
      chk("R11 empty idle", irq, t);
      wr_reg(2'b00, 8'h55);
      chk("R11 tx full", irq, 0);
      rx_push(8'h11, 1'b0);
      chk("R11 rx full", irq, q);
      rx_push(8'h22, 1'b0);
      chk("R11 overrun", irq, q);
      rd_reg(2'b00, r);
      chk("R11 cleared", irq, 0);
      tx_take();
      chk("R11 empty again", irq, t);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule